// File: doc/BRIEF.md
# Exception Frame Push Sequencer

This block runs the memory side of page-fault entry. When a fault is signalled it captures the interrupted context: flags, code selector, instruction pointer, stack selector, stack pointer and error code. It also captures the kernel stack selector and pointer from the task-state record and the handler's code selector and address. It then writes the exception frame word by word through a 32-bit write port. When the last word is written, it issues a one-cycle strobe that redirects execution to the handler.

The privilege level of the interrupted code is the two low bits of its code selector. At level 0 the frame goes onto the current stack and holds four words. At any other level the block first switches to the kernel stack from the task-state record. It then stores the old stack selector and pointer ahead of the four usual words, so the frame holds six words. Each push lowers the stack pointer by four and then writes at the lowered address. When the sequence ends, the stack pointer output addresses the error code, which is the lowest word of the frame.

Top module: `exc_frame_seq`

## Requirements
- R1: After reset, `busy_o`, `mem_wr_o` and `jump_o` are 0, and `new_sp_o`, `new_ss_o`, `new_cs_o` and `new_ip_o` are all 0.
- R2: A fault with code selector bits [1:0] equal to 0 produces exactly four writes on the current stack, in this order: flags, code selector, instruction pointer, error code. They go to addresses `sp_i`-4, -8, -12 and -16.
- R3: A fault with code selector bits [1:0] equal to 1, 2 or 3 switches to `tss_ss_i`/`tss_sp_i`. It produces six writes, in this order: old stack selector, old stack pointer, flags, code selector, instruction pointer, error code. They go to `tss_sp_i`-4 through -24.
- R4: A write request stays asserted until `mem_ack_i`, with address and data held steady. An acknowledged write lowers `new_sp_o` by 4 in the next cycle.
- R5: Selectors are zero-extended to 32 bits in the frame. All captured values are taken in the cycle the fault is accepted, and later input changes have no effect. The saved instruction pointer is the one given with the fault.
- R6: The cycle after the last acknowledge, `jump_o` is high for exactly one cycle. At that point `new_ip_o` equals the handler address, `new_cs_o` equals the handler selector with bits [1:0] cleared, `new_ss_o` is the selected stack selector, and `new_sp_o` is the start pointer minus 4 times the frame length.
- R7: `busy_o` is high from the cycle after a fault is accepted through the jump cycle. A fault raised while busy is ignored and starts no second frame.
- R8: Stack pointer arithmetic wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fault_i | input | 1 | Fault request, accepted when idle |
| flags_i | input | 32 | Current flags word |
| cs_i | input | 16 | Current code selector, bits [1:0] are the privilege level |
| ip_i | input | 32 | Address of the faulting instruction |
| ss_i | input | 16 | Current stack selector |
| sp_i | input | 32 | Current stack pointer |
| err_i | input | 32 | Fault error code |
| tss_ss_i | input | 16 | Kernel stack selector from the task-state record |
| tss_sp_i | input | 32 | Kernel stack pointer from the task-state record |
| hnd_cs_i | input | 16 | Handler code selector |
| hnd_ip_i | input | 32 | Handler entry address |
| mem_ack_i | input | 1 | Write acknowledge |
| mem_wr_o | output | 1 | Write request |
| mem_addr_o | output | 32 | Write byte address |
| mem_wdata_o | output | 32 | Write data |
| busy_o | output | 1 | Sequence in progress |
| new_ss_o | output | 16 | Stack selector in use |
| new_sp_o | output | 32 | Running stack pointer |
| new_cs_o | output | 16 | Handler code selector with privilege forced to 0 |
| new_ip_o | output | 32 | Handler address |
| jump_o | output | 1 | One-cycle redirect strobe |

## Verification
The bench covers privilege levels 1 and 2 as well as 0 and 3. A design that tested only for level 3 would put those faults on the current stack and write four words instead of six. It scrambles every input right after acceptance, which exposes a design that reads the live inputs instead of its captured copies. It also stalls acknowledges for random lengths, so a design that advanced without an acknowledge would skip frame words. It raises a second fault mid-sequence and starts a kernel stack near address zero, which catch a mid-frame restart (corrupted words) and broken pointer wrap (wrong addresses).

// File: rtl/exc_frame_pkg.sv
package exc_frame_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_JUMP = 2'd2
    } seq_state_e;

    localparam int STEP_W     = 3;
    localparam int USER_WORDS = 6;
    localparam int KERN_WORDS = 4;
endpackage

// File: rtl/stack_ptr_dec.sv
module stack_ptr_dec #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] sp_i,
    output logic [ADDR_W-1:0] sp_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    // R8: plain modular subtraction
    assign sp_o = sp_i - STEP;
endmodule

// File: rtl/frame_word_sel.sv
module frame_word_sel
    import exc_frame_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic [STEP_W-1:0] step_i,
    input  logic              user_i,
    input  logic [SEL_W-1:0]  oss_i,
    input  logic [ADDR_W-1:0] osp_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [SEL_W-1:0]  cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [DATA_W-1:0] err_i,
    output logic [DATA_W-1:0] word_o,
    output logic              last_o
);
    localparam int SKIP = USER_WORDS - KERN_WORDS;

    logic [STEP_W-1:0] slot;

    always_comb begin
        slot = user_i ? step_i : step_i + STEP_W'(SKIP);
        unique case (slot)
            3'd0:    word_o = DATA_W'(oss_i);
            3'd1:    word_o = DATA_W'(osp_i);
            3'd2:    word_o = flags_i;
            3'd3:    word_o = DATA_W'(cs_i);
            3'd4:    word_o = ip_i;
            default: word_o = err_i;
        endcase
        last_o = (slot == STEP_W'(USER_WORDS - 1));
    end
endmodule

// File: rtl/exc_frame_seq.sv
module exc_frame_seq
    import exc_frame_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int SEL_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_i,
    input  logic [DATA_W-1:0] flags_i,
    input  logic [SEL_W-1:0]  cs_i,
    input  logic [DATA_W-1:0] ip_i,
    input  logic [SEL_W-1:0]  ss_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] err_i,
    input  logic [SEL_W-1:0]  tss_ss_i,
    input  logic [ADDR_W-1:0] tss_sp_i,
    input  logic [SEL_W-1:0]  hnd_cs_i,
    input  logic [ADDR_W-1:0] hnd_ip_i,
    input  logic              mem_ack_i,
    output logic              mem_wr_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic [SEL_W-1:0]  new_ss_o,
    output logic [ADDR_W-1:0] new_sp_o,
    output logic [SEL_W-1:0]  new_cs_o,
    output logic [ADDR_W-1:0] new_ip_o,
    output logic              jump_o
);
    localparam int WORD_BYTES = DATA_W / 8;

    typedef struct packed {
        seq_state_e        st;
        logic [STEP_W-1:0] step;
        logic              user;
        logic [ADDR_W-1:0] sp;
        logic [SEL_W-1:0]  ss;
        logic [SEL_W-1:0]  oss;
        logic [ADDR_W-1:0] osp;
        logic [DATA_W-1:0] flags;
        logic [SEL_W-1:0]  cs;
        logic [DATA_W-1:0] ip;
        logic [DATA_W-1:0] err;
        logic [SEL_W-1:0]  hcs;
        logic [ADDR_W-1:0] hip;
    } seq_regs_t;

    seq_regs_t         q, d;
    logic [ADDR_W-1:0] sp_next;
    logic [DATA_W-1:0] word;
    logic              last;
    logic              wr_d, jump_d;
    logic              user_fault;

    stack_ptr_dec #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_dec (
        .sp_i (q.sp),
        .sp_o (sp_next)
    );

    frame_word_sel #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEL_W(SEL_W)) u_sel (
        .step_i  (q.step),
        .user_i  (q.user),
        .oss_i   (q.oss),
        .osp_i   (q.osp),
        .flags_i (q.flags),
        .cs_i    (q.cs),
        .ip_i    (q.ip),
        .err_i   (q.err),
        .word_o  (word),
        .last_o  (last)
    );

    assign user_fault = (cs_i[1:0] != 2'b00);

    always_comb begin
        d      = q;
        wr_d   = 1'b0;
        jump_d = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (fault_i) begin
                    d.st    = ST_PUSH;
                    d.step  = '0;
                    d.user  = user_fault;
                    d.ss    = user_fault ? tss_ss_i : ss_i;
                    d.sp    = user_fault ? tss_sp_i : sp_i;
                    d.oss   = ss_i;
                    d.osp   = sp_i;
                    d.flags = flags_i;
                    d.cs    = cs_i;
                    d.ip    = ip_i;
                    d.err   = err_i;
                    d.hcs   = hnd_cs_i;
                    d.hip   = hnd_ip_i;
                end
            end
            ST_PUSH: begin
                wr_d = 1'b1;
                if (mem_ack_i) begin
                    d.sp   = sp_next;
                    d.step = q.step + 1'b1;
                    if (last) d.st = ST_JUMP;
                end
            end
            default: begin
                jump_d = 1'b1;
                d.st   = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign mem_wr_o    = wr_d;
    assign mem_addr_o  = sp_next;
    assign mem_wdata_o = word;
    assign busy_o      = (q.st != ST_IDLE);
    assign jump_o      = jump_d;
    assign new_ss_o    = q.ss;
    assign new_sp_o    = q.sp;
    assign new_cs_o    = {q.hcs[SEL_W-1:2], 2'b00};
    assign new_ip_o    = q.hip;

    // R4
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && !mem_ack_i) |=> (mem_wr_o && $stable(mem_addr_o) && $stable(mem_wdata_o)));
    // R4
    sp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o && mem_ack_i) |=> (new_sp_o == $past(new_sp_o) - ADDR_W'(WORD_BYTES)));
    // R6
    jump_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |=> (!jump_o && !busy_o));
    // R6
    jump_rpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        jump_o |-> (new_cs_o[1:0] == 2'b00));
    // R7
    busy_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_o || jump_o) |-> busy_o);
    // R7
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !jump_o) |=> busy_o);
endmodule

// File: tb/tb_exc_frame_seq.sv
`timescale 1ns/1ps
module tb_exc_frame_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fault_i = 1'b0;
    logic [31:0] flags_i = '0, ip_i = '0, sp_i = '0, err_i = '0, tss_sp_i = '0, hnd_ip_i = '0;
    logic [15:0] cs_i = '0, ss_i = '0, tss_ss_i = '0, hnd_cs_i = '0;
    logic        mem_ack_i = 1'b0;
    logic        mem_wr_o, busy_o, jump_o;
    logic [31:0] mem_addr_o, mem_wdata_o, new_sp_o, new_ip_o;
    logic [15:0] new_ss_o, new_cs_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    exc_frame_seq dut (
        .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .flags_i(flags_i), .cs_i(cs_i),
        .ip_i(ip_i), .ss_i(ss_i), .sp_i(sp_i), .err_i(err_i), .tss_ss_i(tss_ss_i),
        .tss_sp_i(tss_sp_i), .hnd_cs_i(hnd_cs_i), .hnd_ip_i(hnd_ip_i),
        .mem_ack_i(mem_ack_i), .mem_wr_o(mem_wr_o), .mem_addr_o(mem_addr_o),
        .mem_wdata_o(mem_wdata_o), .busy_o(busy_o), .new_ss_o(new_ss_o),
        .new_sp_o(new_sp_o), .new_cs_o(new_cs_o), .new_ip_o(new_ip_o), .jump_o(jump_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // frame word k for a fault; user frames have 6 words, kernel frames 4
    function automatic logic [31:0] exp_word(input int k, input bit user, input logic [15:0] oss,
            input logic [31:0] osp, input logic [31:0] fl, input logic [15:0] cs,
            input logic [31:0] ip, input logic [31:0] er);
        int s = user ? k : k + 2;
        case (s)
            0:       return {16'h0, oss};
            1:       return osp;
            2:       return fl;
            3:       return {16'h0, cs};
            4:       return ip;
            default: return er;
        endcase
    endfunction

    task automatic run_fault(input logic [15:0] cs, input logic [31:0] sp,
                             input logic [31:0] ksp, input bit poke_busy);
        logic [31:0] fl = $urandom, ip = $urandom, er = $urandom, hip = $urandom;
        logic [15:0] ss = 16'($urandom), kss = 16'($urandom), hcs = 16'($urandom);
        bit          user = (cs[1:0] != 2'b00);
        int          nw = user ? 6 : 4;
        logic [31:0] base = user ? ksp : sp;
        string       rq = user ? "R3" : "R2";
        flags_i = fl; cs_i = cs; ip_i = ip; ss_i = ss; sp_i = sp; err_i = er;
        tss_ss_i = kss; tss_sp_i = ksp; hnd_cs_i = hcs; hnd_ip_i = hip;
        fault_i = 1'b1;
        @(negedge clk);
        fault_i = 1'b0;
        // R5: scramble inputs after acceptance
        flags_i = $urandom; cs_i = 16'($urandom); ip_i = $urandom; ss_i = 16'($urandom);
        sp_i = $urandom; err_i = $urandom; tss_sp_i = $urandom; tss_ss_i = 16'($urandom);
        hnd_cs_i = 16'($urandom); hnd_ip_i = $urandom;
        check("R7 busy after accept", 32'(busy_o), 32'd1);
        for (int k = 0; k < nw; k++) begin
            int dly = $urandom_range(0, 3);
            check({rq, " write request"}, 32'(mem_wr_o), 32'd1);
            check({rq, " address"}, mem_addr_o, base - 32'(4 * (k + 1)));
            check({rq, " R5 data"}, mem_wdata_o, exp_word(k, user, ss, sp, fl, cs, ip, er));
            for (int w = 0; w < dly; w++) begin
                if (poke_busy && k == 1 && w == 0) fault_i = 1'b1;
                @(negedge clk);
                fault_i = 1'b0;
                check("R4 hold addr", mem_addr_o, base - 32'(4 * (k + 1)));
                check("R4 hold req", 32'(mem_wr_o), 32'd1);
            end
            if (poke_busy && k == 1 && dly == 0) begin
                fault_i = 1'b1;
            end
            mem_ack_i = 1'b1;
            @(negedge clk);
            mem_ack_i = 1'b0;
            fault_i = 1'b0;
            check("R4 sp step", new_sp_o, base - 32'(4 * (k + 1)));
        end
        check("R6 jump strobe", 32'(jump_o), 32'd1);
        check("R6 no write at jump", 32'(mem_wr_o), 32'd0);
        check("R6 new ip", new_ip_o, hip);
        check("R6 new cs", {16'h0, new_cs_o}, {16'h0, hcs[15:2], 2'b00});
        check("R6 new ss", {16'h0, new_ss_o}, {16'h0, user ? kss : ss});
        check("R6 R8 new sp", new_sp_o, base - 32'(4 * nw));
        @(negedge clk);
        check("R6 strobe single", 32'(jump_o), 32'd0);
        check("R7 idle after jump", 32'(busy_o), 32'd0);
        if (poke_busy) begin
            repeat (3) begin
                @(negedge clk);
                check("R7 ignored fault no write", 32'(mem_wr_o), 32'd0);
                check("R7 ignored fault not busy", 32'(busy_o), 32'd0);
            end
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_0001));
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(busy_o), 32'd0);
        check("R1 wr", 32'(mem_wr_o), 32'd0);
        check("R1 jump", 32'(jump_o), 32'd0);
        check("R1 sp", new_sp_o, 32'd0);
        check("R1 ss cs", {new_ss_o, new_cs_o}, 32'd0);
        check("R1 ip", new_ip_o, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed: each privilege level
        run_fault(16'h0010, 32'h0000_8000, 32'hC000_1000, 1'b0);
        run_fault(16'h0011, 32'h0000_8000, 32'hC000_2000, 1'b0);
        run_fault(16'h0012, 32'h0000_8000, 32'hC000_3000, 1'b0);
        run_fault(16'h0013, 32'h0000_8000, 32'hC000_4000, 1'b0);
        // R8 wrap near zero, kernel and user
        run_fault(16'h0008, 32'h0000_0008, 32'h1234_5678, 1'b0);
        run_fault(16'h001B, 32'h0000_0100, 32'h0000_000C, 1'b0);
        // R7 fault while busy
        run_fault(16'h0023, 32'h0001_0000, 32'h8000_0000, 1'b1);
        run_fault(16'h0020, 32'h0001_0000, 32'h8000_0000, 1'b1);
        for (int t = 0; t < 40; t++) begin
            run_fault(16'($urandom), {$urandom} & 32'hFFFF_FFFC, {$urandom} & 32'hFFFF_FFFC,
                      ($urandom_range(0, 3) == 0));
            repeat ($urandom_range(0, 2)) @(negedge clk);
        end
        finish_run();
    end
endmodule